// File: doc/BRIEF.md
# Eight-Pin GPIO Register Block

This block is a register-mapped controller for eight general-purpose pins on a zero-wait 32-bit APB-style bus. Each pin has a direction bit and an output latch. When the direction bit is 1, the pad driver is enabled and drives the latch value. When the direction bit is 0, the latch keeps its value but the pad is not driven.

Software can update the latch in three ways:
- a plain write to the output data word;
- a write-only word that carries set requests and clear requests together, so that several pins change in one atomic access;
- a second write-only word that only clears.

Neither write-only word needs a read-modify-write. The pad levels pass through a two-flop synchronizer and can be read back as a status word. One control bit is brought out on a dedicated port. It grants a DMA engine access to the block while the chip is in deep power-down.

The bus is decoded on word addresses. Address bits 1:0 are ignored. A write takes effect at the clock edge of its access phase, that is, the edge where `psel_i`, `penable_i` and `pwrite_i` are all high. Read data is combinational whenever `psel_i` is high and `pwrite_i` is low, and is 0 otherwise.

Top module: `gpio8_regs`

## Requirements
- R1: While reset (active-low `rst_ni`) is asserted, `pin_oe_o`, `pin_o` and `dma_lp_en_o` are all 0, and the mode and output-data words read 0 after reset is released.
- R2: A write to byte offset 0x00 loads bits 7:0 into the direction bits, so that `pin_oe_o[n]` is 1 for output and 0 for input. The same write loads bit 31 into `dma_lp_en_o`. A read of 0x00 returns the direction bits in 7:0, the DMA bit in bit 31, and 0 in bits 30:8.
- R3: A write to offset 0x04 loads bits 7:0 into the output latch, which appears on `pin_o`. A read of 0x04 returns the latch in bits 7:0 and 0 in bits 31:8.
- R4: A read of offset 0x08 returns in bits 7:0 the value `pin_i` had two rising clock edges earlier, and 0 in bits 31:8. Writes to 0x08 change nothing.
- R5: A write to offset 0x0C sets latch bit n when data bit n is 1. It clears latch bit n when data bit 16+n is 1 and data bit n is 0. Latch bits whose two request bits are both 0 keep their value.
- R6: In a write to 0x0C, when data bits n and 16+n are both 1, latch bit n becomes 1.
- R7: A write to offset 0x10 clears latch bit n for every data bit n (7:0) that is 1 and leaves the other latch bits unchanged. The result is visible when 0x04 is read.
- R8: Reads of 0x0C, 0x10 and of the undefined offsets 0x14 to 0x1C return 0. Writes to the undefined offsets change no state.
- R9: Register changes appear on the output ports in the first cycle after the access-phase edge. A setup phase alone (`psel_i` high, `penable_i` low) changes no state, and in a cycle with no access-phase write the outputs hold.
- R10: While a pin is in input mode, its latch value still reaches `pin_o` and can be updated, but `pin_oe_o` stays 0. Returning the pin to output mode drives the held latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 5 | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, 0 when no read is selected |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Output latch to the pad drivers |
| pin_oe_o | output | 8 | Per-pin driver enable (the direction bits) |
| dma_lp_en_o | output | 1 | DMA access enable for low-power modes |

## Verification
All of the block's state sits directly on its output ports: the latch on `pin_o`, the direction bits on `pin_oe_o`, and the DMA bit on its own pin. A wrong latch update, such as a lost set priority, a clear that leaks into a neighbouring pin, or a write taken in the setup phase, therefore shows on the ports in the first cycle after the offending edge. A per-cycle comparison against a behavioural model catches it at once. A synchronizer of the wrong depth shows only through the status word, as read data that arrives one cycle early or one cycle late relative to the pad edge. It is caught by holding a read open across a pad transition.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  localparam int unsigned IDX_MODE   = 0;
  localparam int unsigned IDX_DOUT   = 1;
  localparam int unsigned IDX_PIN    = 2;
  localparam int unsigned IDX_SETCLR = 3;
  localparam int unsigned IDX_CLR    = 4;
  // clear requests in the combined word start here
  localparam int unsigned CLR_SHIFT  = 16;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_DOUT,
    SEL_PIN
  } rd_sel_e;

  typedef struct packed {
    logic mode;
    logic dout;
    logic setclr;
    logic clr;
  } wr_stb_t;
endpackage

// File: rtl/gpio8_decode.sv
module gpio8_decode
  import gpio8_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output wr_stb_t           wr_o,
  output rd_sel_e           rd_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic             rd_en;
  logic             unused_addr;

  assign idx         = paddr_i[ADDR_W-1:2];
  assign wr_en       = psel_i & penable_i & pwrite_i;
  assign rd_en       = psel_i & ~pwrite_i;
  assign unused_addr = ^paddr_i[1:0];

  always_comb begin
    wr_o.mode   = wr_en && (idx == IDX_W'(IDX_MODE));
    wr_o.dout   = wr_en && (idx == IDX_W'(IDX_DOUT));
    wr_o.setclr = wr_en && (idx == IDX_W'(IDX_SETCLR));
    wr_o.clr    = wr_en && (idx == IDX_W'(IDX_CLR));
  end

  always_comb begin
    rd_o = SEL_NONE;
    if (rd_en) begin
      if (idx == IDX_W'(IDX_MODE))      rd_o = SEL_MODE;
      else if (idx == IDX_W'(IDX_DOUT)) rd_o = SEL_DOUT;
      else if (idx == IDX_W'(IDX_PIN))  rd_o = SEL_PIN;
    end
  end
endmodule

// File: rtl/gpio8_latch.sv
module gpio8_latch
  import gpio8_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  wr_stb_t             wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] mode_o,
  output logic [NUM_PINS-1:0] dout_o,
  output logic                dma_o
);
  localparam int unsigned DMA_BIT = DATA_W - 1;

  logic [NUM_PINS-1:0] mode_q;
  logic [NUM_PINS-1:0] dout_q;
  logic                dma_q;
  logic                unused_wdata;

  assign unused_wdata = ^{wdata_i[DMA_BIT-1:CLR_SHIFT+NUM_PINS],
                          wdata_i[CLR_SHIFT-1:NUM_PINS]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dma_q  <= 1'b0;
    end else if (wr_i.mode) begin
      mode_q <= wdata_i[NUM_PINS-1:0];
      dma_q  <= wdata_i[DMA_BIT];
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    // priority: direct write, then set, then either clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dout_q[n] <= 1'b0;
      end else if (wr_i.dout) begin
        dout_q[n] <= wdata_i[n];
      end else if (wr_i.setclr && wdata_i[n]) begin
        dout_q[n] <= 1'b1;
      end else if (wr_i.setclr && wdata_i[CLR_SHIFT+n]) begin
        dout_q[n] <= 1'b0;
      end else if (wr_i.clr && wdata_i[n]) begin
        dout_q[n] <= 1'b0;
      end
    end
  end

  assign mode_o = mode_q;
  assign dout_o = dout_q;
  assign dma_o  = dma_q;
endmodule

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic [DATA_W-1:0]   pwdata_i,
  output logic [DATA_W-1:0]   prdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                dma_lp_en_o
);
  localparam int unsigned DMA_BIT = DATA_W - 1;

  wr_stb_t             wr;
  rd_sel_e             rd_sel;
  logic [NUM_PINS-1:0] mode;
  logic [NUM_PINS-1:0] dout;
  logic [NUM_PINS-1:0] pin_sync;
  logic                dma_en;

  gpio8_decode #(.ADDR_W(ADDR_W)) u_decode (
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .wr_o     (wr),
    .rd_o     (rd_sel)
  );

  gpio8_latch #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .wdata_i(pwdata_i),
    .mode_o (mode),
    .dout_o (dout),
    .dma_o  (dma_en)
  );

  gpio8_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  always_comb begin
    prdata_o = '0;
    case (rd_sel)
      SEL_MODE: begin
        prdata_o[NUM_PINS-1:0] = mode;
        prdata_o[DMA_BIT]      = dma_en;
      end
      SEL_DOUT: prdata_o[NUM_PINS-1:0] = dout;
      SEL_PIN:  prdata_o[NUM_PINS-1:0] = pin_sync;
      default:  prdata_o = '0;
    endcase
  end

  assign pin_o       = dout;
  assign pin_oe_o    = mode;
  assign dma_lp_en_o = dma_en;
endmodule

// File: rtl/gpio8_regs_chk.sv
module gpio8_regs_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                psel_i,
  input logic                penable_i,
  input logic                pwrite_i,
  input logic [ADDR_W-1:0]   paddr_i,
  input logic [DATA_W-1:0]   pwdata_i,
  input logic [DATA_W-1:0]   prdata_o,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                dma_lp_en_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned CS    = gpio8_pkg::CLR_SHIFT;

  logic [IDX_W-1:0]    idx;
  logic                wr_any, wr_mode, wr_setclr, wr_clr, rd_wo;
  logic [NUM_PINS-1:0] set_v, clr_v;
  logic                unused_chk;

  assign idx       = paddr_i[ADDR_W-1:2];
  assign wr_any    = psel_i & penable_i & pwrite_i;
  assign wr_mode   = wr_any && (idx == IDX_W'(0));
  assign wr_setclr = wr_any && (idx == IDX_W'(3));
  assign wr_clr    = wr_any && (idx == IDX_W'(4));
  assign rd_wo     = psel_i && !pwrite_i && (idx >= IDX_W'(3));
  assign set_v     = pwdata_i[NUM_PINS-1:0];
  assign clr_v     = pwdata_i[CS +: NUM_PINS];
  assign unused_chk = ^{pin_i, paddr_i[1:0],
                        pwdata_i[DATA_W-2:CS+NUM_PINS], pwdata_i[CS-1:NUM_PINS]};

  assert_mode_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mode |=> (pin_oe_o == $past(set_v)) && (dma_lp_en_o == $past(pwdata_i[DATA_W-1])));

  assert_setclr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_setclr |=> pin_o == (($past(pin_o) | $past(set_v)) & ~($past(clr_v) & ~$past(set_v))));

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_setclr |=> ((pin_o & $past(set_v & clr_v)) == $past(set_v & clr_v)));

  assert_clr_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> pin_o == ($past(pin_o) & ~$past(set_v)));

  assert_wo_reads_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_wo |-> prdata_o == '0);

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any |=> $stable(pin_o) && $stable(pin_oe_o) && $stable(dma_lp_en_o));
endmodule

bind gpio8_regs gpio8_regs_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .psel_i     (psel_i),
  .penable_i  (penable_i),
  .pwrite_i   (pwrite_i),
  .paddr_i    (paddr_i),
  .pwdata_i   (pwdata_i),
  .prdata_o   (prdata_o),
  .pin_i      (pin_i),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .dma_lp_en_o(dma_lp_en_o)
);

// File: tb/gpio8_regs_bench.sv
module gpio8_regs_bench;
  localparam int N = 8, AW = 5, DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata, prdata;
  logic [N-1:0]  pin_drv, pin_o, pin_oe;
  logic          dma_o;

  int total = 0;
  int bad   = 0;
  bit cmp_on = 0;

  always #5 clk_i = ~clk_i;

  gpio8_regs u_gpio8_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pin_i(pin_drv), .pin_o(pin_o), .pin_oe_o(pin_oe), .dma_lp_en_o(dma_o)
  );

  // behavioural reference model
  logic [N-1:0] m_mode, m_dout, m_h0, m_h1;
  logic         m_dma;

  always @(posedge clk_i or negedge rst_ni) begin
    logic [N-1:0] t;
    if (!rst_ni) begin
      m_mode <= '0; m_dout <= '0; m_dma <= 1'b0; m_h0 <= '0; m_h1 <= '0;
    end else begin
      m_h0 <= pin_drv;
      m_h1 <= m_h0;
      if (psel && penable && pwrite) begin
        t = m_dout;
        case (int'(paddr) / 4)
          0: begin m_mode <= pwdata[7:0]; m_dma <= pwdata[31]; end
          1: t = pwdata[7:0];
          3: for (int n = 0; n < N; n++) begin
               if (pwdata[n]) t[n] = 1'b1;
               else if (pwdata[16+n]) t[n] = 1'b0;
             end
          4: t = t & ~pwdata[7:0];
          default: ;
        endcase
        m_dout <= t;
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    case (int'(a) / 4)
      0: return {m_dma, 23'd0, m_mode};
      1: return {24'd0, m_dout};
      2: return {24'd0, m_h1};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_on && rst_ni) begin
      check("R9 pin_oe per-cycle", 32'(pin_oe), 32'(m_mode));
      check("R9 pin_o per-cycle",  32'(pin_o),  32'(m_dout));
      check("R9 dma per-cycle",    32'(dma_o),  32'(m_dma));
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk_i);
    penable = 1;
    @(negedge clk_i);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    @(negedge clk_i);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk_i);
    penable = 1;
    #1 v = prdata;
    check(tag, v, exp);
    check({tag, " model"}, v, model_read(a));
    @(negedge clk_i);
    psel = 0; penable = 0;
  endtask

  initial begin
    rst_ni = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pin_drv = '0;
    repeat (3) @(posedge clk_i);
    #2;
    check("R1 oe in reset",  32'(pin_oe), 0);
    check("R1 out in reset", 32'(pin_o), 0);
    check("R1 dma in reset", 32'(dma_o), 0);
    @(negedge clk_i);
    rst_ni = 1;
    cmp_on = 1;
    rd("R1 mode after reset", 5'h00, 32'h0);
    rd("R1 dout after reset", 5'h04, 32'h0);

    wr(5'h00, 32'h8000_00A5);
    check("R2 oe", 32'(pin_oe), 32'hA5);
    check("R2 dma", 32'(dma_o), 1);
    rd("R2 mode read", 5'h00, 32'h8000_00A5);
    wr(5'h00, 32'hFFFF_FFFF);
    rd("R2 reserved bits zero", 5'h00, 32'h8000_00FF);

    wr(5'h04, 32'h1234_5A3C);
    check("R9 R3 pin_o first cycle", 32'(pin_o), 32'h3C);
    rd("R3 dout read", 5'h04, 32'h0000_003C);

    wr(5'h0C, 32'h000C_0041);
    rd("R5 set and clear", 5'h04, 32'h71);
    wr(5'h0C, 32'h0003_0002);
    check("R6 set wins pin_o", 32'(pin_o), 32'h72);
    wr(5'h0C, 32'h0000_0000);
    rd("R5 zero no effect", 5'h04, 32'h72);

    wr(5'h10, 32'hFFFF_FF30);
    rd("R7 clear-only readback", 5'h04, 32'h42);

    rd("R8 setclr reads zero", 5'h0C, 32'h0);
    rd("R8 clr reads zero", 5'h10, 32'h0);
    rd("R8 undefined 0x14", 5'h14, 32'h0);
    rd("R8 undefined 0x1C", 5'h1C, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    rd("R8 mode untouched", 5'h00, 32'h8000_00FF);
    rd("R4 R8 dout untouched", 5'h04, 32'h42);

    // setup phase only
    @(negedge clk_i);
    psel = 1; pwrite = 1; penable = 0; paddr = 5'h04; pwdata = 32'hFF;
    @(negedge clk_i);
    psel = 0; pwrite = 0;
    rd("R9 setup-only ignored", 5'h04, 32'h42);

    wr(5'h00, 32'h0);
    check("R10 oe off", 32'(pin_oe), 0);
    check("R10 latch held", 32'(pin_o), 32'h42);
    wr(5'h0C, 32'h80);
    check("R10 update while input", 32'(pin_o), 32'hC2);
    wr(5'h00, 32'h0F);
    check("R10 back to output", 32'(pin_o), 32'hC2);
    rd("R10 R2 mode read", 5'h00, 32'h0000_000F);

    @(negedge clk_i);
    pin_drv = 8'h96;
    repeat (3) @(negedge clk_i);
    rd("R4 pin status", 5'h08, 32'h96);

    // hold a read of 0x08 across a pad edge
    @(negedge clk_i);
    psel = 1; pwrite = 0; penable = 1; paddr = 5'h08;
    @(negedge clk_i);
    pin_drv = 8'h5A;
    #1 check("R4 lag cycle 0", prdata, 32'h96);
    @(negedge clk_i);
    #1 check("R4 lag cycle 1", prdata, 32'h96);
    @(negedge clk_i);
    #1 check("R4 lag cycle 2", prdata, 32'h5A);
    psel = 0; penable = 0;

    repeat (2) @(negedge clk_i);
    cmp_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule